// File: doc/BRIEF.md
# Modem Event Status Register

This block holds the 16-bit status word of a half-duplex field-bus modem. Two kinds of bits share the word.

- **Event flags** latch a single-cycle pulse and stay at 1 until software writes a 1 to that bit position.
- **Condition bits** show the present state of the FIFOs, the carrier detector and the jabber inhibitor. They follow their inputs and cannot be set or cleared by software.

The block also produces clear-to-send. It is granted while request-to-send is high and the line is quiet. In full-duplex operation it follows request-to-send alone.

Software sees the whole word on a plain read bus. It clears flags by presenting a write strobe with a data mask. An interrupt line is high whenever any event flag is pending. The event sources, FIFOs, jabber timer and host serial interface live elsewhere; the block sees them only as input pins. All interface pins are plain level or pulse signals, and there is no data stream. Because of that, no valid/ready handshake and no back-pressure rule apply.

Every register updates on the rising clock edge. A change on any input therefore shows on the read bus, `cts` and `irq` one cycle later.

Top module: `modem_stat_reg`

## Requirements
- R1: While `rst_n` is low, `stat_word`, `cts` and `irq` are all 0, whatever the inputs do.
- R2: On the first clock edge after `rst_n` goes high, bit 15 (reset-seen) becomes 1. It stays 1 until a write with bit 15 of `wr_data` at 1.
- R3: A one-cycle pulse on `evt_gap`, `evt_frame`, `evt_parity`, `evt_wdog` or `evt_crc` sets bit 12, 11, 10, 9 or 8 respectively. The bit then stays 1 for as long as no clearing write occurs.
- R4: A write (`wr_en`=1) clears each sticky bit (15, 12..8) whose `wr_data` bit is 1. It leaves sticky bits whose `wr_data` bit is 0 unchanged.
- R5: If an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up 1.
- R6: Condition bits show their input one cycle later, as follows:
  - bit 14: `jab_expired`
  - bit 13: `jab_active`
  - bit 7: `rx_at_lvl`
  - bit 6: `rx_full`
  - bit 5: `rx_empty`
  - bit 4: `tx_at_lvl`
  - bit 3: `tx_full`
  - bit 2: `tx_empty`
  - bit 1: `carrier`
- R7: Writes of any value have no effect on bits 14, 13 and 7..0; these bits still follow their inputs.
- R8: With `full_duplex`=0, `cts` and bit 0 become `rts AND NOT carrier` one cycle later.
- R9: With `full_duplex`=1, `cts` and bit 0 become `rts` one cycle later, regardless of `carrier`.
- R10: `irq` is 1 exactly when at least one sticky bit (15, 12..8) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for clearing flags |
| wr_data | input | 16 | Write mask; a 1 clears the matching sticky bit |
| evt_gap | input | 1 | Gap error pulse |
| evt_frame | input | 1 | Frame error / half-bit slip pulse |
| evt_parity | input | 1 | Parity error pulse |
| evt_wdog | input | 1 | Watchdog expiry pulse |
| evt_crc | input | 1 | Host command CRC error pulse |
| jab_expired | input | 1 | Jabber timeout has expired |
| jab_active | input | 1 | Jabber inhibitor is engaged |
| rx_at_lvl | input | 1 | Receive FIFO at programmed level |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_at_lvl | input | 1 | Transmit FIFO at programmed level |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| carrier | input | 1 | Carrier detected on the line |
| rts | input | 1 | Request-to-send |
| full_duplex | input | 1 | Full-duplex operation select |
| stat_word | output | 16 | Status word read bus |
| cts | output | 1 | Clear-to-send |
| irq | output | 1 | Pending-event interrupt |

## Verification
The hardest situation to reach is a clearing write and an event pulse landing on the same flag in the same cycle. The stimulus first sets the CRC flag. In a later cycle it drives `evt_crc` together with a write whose mask has bit 8 set, then checks that the flag survives. A following clear with no pulse shows that the bit can still be cleared.

The reset-seen flag rises only on the single edge after reset release. To catch it, the scoreboard holds an expected word for that very first cycle.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;
  localparam int WORD_W   = 16;
  localparam int N_STICKY = 6;   // reset-seen, gap, frame, parity, wdog, crc
  localparam int N_LIVE   = 9;   // jabber x2, fifo x6, carrier
  localparam logic [WORD_W-1:0] STICKY_MASK = 16'h9F00;
  localparam logic [WORD_W-1:0] LIVE_MASK   = 16'h60FE;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set has priority
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/live_mirror.sv
module live_mirror #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/cts_gen.sv
module cts_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_i,
  input  logic carrier_i,
  input  logic full_duplex_i,
  output logic cts_o
);
  logic grant;
  always_comb grant = rts_i & (full_duplex_i | ~carrier_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_o <= 1'b0;
    else        cts_o <= grant;
  end
endmodule

// File: rtl/modem_stat_reg.sv
module modem_stat_reg
  import modem_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              evt_gap,
  input  logic              evt_frame,
  input  logic              evt_parity,
  input  logic              evt_wdog,
  input  logic              evt_crc,
  input  logic              jab_expired,
  input  logic              jab_active,
  input  logic              rx_at_lvl,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic              tx_at_lvl,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              carrier,
  input  logic              rts,
  input  logic              full_duplex,
  output logic [WORD_W-1:0] stat_word,
  output logic              cts,
  output logic              irq
);
  logic                booted;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [N_LIVE-1:0]   lv_d, lv_q;

  // One-shot marker: low until the first edge after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) booted <= 1'b0;
    else        booted <= 1'b1;
  end

  always_comb begin
    st_set = {~booted, evt_gap, evt_frame, evt_parity, evt_wdog, evt_crc};
    st_clr = wr_en ? {wr_data[15], wr_data[12:8]} : '0;
    lv_d   = {jab_expired, jab_active, rx_at_lvl, rx_full, rx_empty,
              tx_at_lvl, tx_full, tx_empty, carrier};
  end

  sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(st_clr), .q_o(st_q)
  );

  live_mirror #(.N(N_LIVE)) u_live (
    .clk(clk), .rst_n(rst_n), .d_i(lv_d), .q_o(lv_q)
  );

  cts_gen u_cts (
    .clk(clk), .rst_n(rst_n), .rts_i(rts), .carrier_i(carrier),
    .full_duplex_i(full_duplex), .cts_o(cts)
  );

  always_comb begin
    stat_word = {st_q[5], lv_q[8:7], st_q[4:0], lv_q[6:0], cts};
    irq       = |st_q;
  end
endmodule

// File: rtl/modem_stat_chk.sv
module modem_stat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        evt_gap,
  input logic        evt_crc,
  input logic        carrier,
  input logic        rts,
  input logic        full_duplex,
  input logic [15:0] stat_word,
  input logic        cts,
  input logic        irq
);
  // R3: gap flag holds when not cleared
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[12] && !(wr_en && wr_data[12])) |=> stat_word[12]);

  // R5: event wins over simultaneous clear
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_crc && wr_en && wr_data[8]) |=> stat_word[8]);

  // R6: carrier bit follows carrier input
  assert_cd_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carrier |=> stat_word[1]);

  // R8: carrier blocks CTS in half duplex
  assert_cts_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rts && carrier && !full_duplex) |=> !cts);

  // R9: full duplex grants CTS from RTS alone
  assert_fd_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rts && full_duplex) |=> cts);

  // R10: interrupt matches pending sticky flags
  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|{stat_word[15], stat_word[12:8]}));
endmodule

bind modem_stat_reg modem_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .evt_gap(evt_gap), .evt_crc(evt_crc), .carrier(carrier), .rts(rts),
  .full_duplex(full_duplex), .stat_word(stat_word), .cts(cts), .irq(irq)
);

// File: tb/sim_modem_stat_reg.sv
module sim_modem_stat_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic evt_gap = 0, evt_frame = 0, evt_parity = 0, evt_wdog = 0, evt_crc = 0;
  logic jab_expired = 0, jab_active = 0, rx_at_lvl = 0, rx_full = 0, rx_empty = 0;
  logic tx_at_lvl = 0, tx_full = 0, tx_empty = 0, carrier = 0, rts = 0, full_duplex = 0;
  logic [15:0] stat_word;
  logic cts, irq;

  always #4 clk = ~clk;   // 125 MHz

  modem_stat_reg u0 (.*);

  typedef struct {
    logic [15:0] word;
    logic        c;
    logic        i;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  logic [15:0] m_sticky = '0;
  logic booted = 1'b0;
  bit done = 1'b0;

  // Driver: compute expectation from the inputs now applied, then run one cycle
  task automatic step(input string tag);
    exp_t e;
    logic [15:0] clr, setv;
    clr  = wr_en ? (wr_data & 16'h9F00) : 16'h0;
    setv = {~booted, 2'b00, evt_gap, evt_frame, evt_parity, evt_wdog, evt_crc, 8'h00};
    m_sticky = (m_sticky & ~clr) | setv;
    booted = 1'b1;
    e.c    = rts & (full_duplex | ~carrier);
    e.word = m_sticky | {1'b0, jab_expired, jab_active, 5'b0, rx_at_lvl, rx_full,
                         rx_empty, tx_at_lvl, tx_full, tx_empty, carrier, e.c};
    e.i    = |m_sticky;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    wr_en = 0; wr_data = '0;
    evt_gap = 0; evt_frame = 0; evt_parity = 0; evt_wdog = 0; evt_crc = 0;
  endtask

  // Monitor: compare just after each edge
  initial forever begin
    @(posedge clk);
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (stat_word !== e.word || cts !== e.c || irq !== e.i) begin
        n_bad++;
        $display("FAIL %s: word=%h cts=%b irq=%b expected word=%h cts=%b irq=%b",
                 e.tag, stat_word, cts, irq, e.word, e.c, e.i);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    // R1: active inputs while in reset
    rts = 1; tx_empty = 1; evt_gap = 1; jab_active = 1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (stat_word !== 16'h0 || cts !== 1'b0 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: word=%h cts=%b irq=%b expected 0000/0/0", stat_word, cts, irq);
    end
    rts = 0; tx_empty = 0; evt_gap = 0; jab_active = 0;
    rst_n = 1;
    step("R2 reset-seen on first edge");
    step("R2 reset-seen holds");
    wr_en = 1; wr_data = 16'h0000; step("R4 write zero keeps flags");
    wr_en = 1; wr_data = 16'h8000; step("R2 clear reset-seen");
    step("R10 idle no irq");
    evt_gap = 1;    step("R3 gap pulse");
    evt_frame = 1;  step("R3 frame pulse");
    evt_parity = 1; step("R3 parity pulse");
    evt_wdog = 1;   step("R3 wdog pulse");
    evt_crc = 1;    step("R3 crc pulse");
    step("R3 all flags hold");
    wr_en = 1; wr_data = 16'h1000; step("R4 clear gap only");
    evt_crc = 1; wr_en = 1; wr_data = 16'h0100; step("R5 set beats clear");
    wr_en = 1; wr_data = 16'h0100; step("R4 clear crc after collision");
    wr_en = 1; wr_data = 16'h9F00; step("R10 clear all irq drops");
    jab_expired = 1; rx_at_lvl = 1; rx_empty = 1; tx_full = 1; step("R6 live pattern A");
    jab_expired = 0; jab_active = 1; rx_at_lvl = 0; rx_full = 1; rx_empty = 0;
    tx_at_lvl = 1; tx_full = 0; tx_empty = 1; step("R6 live pattern B");
    wr_en = 1; wr_data = 16'hFFFF; step("R7 write all ones to live bits");
    jab_active = 0; rx_full = 0; tx_at_lvl = 0; tx_empty = 0;
    wr_en = 1; wr_data = 16'h60FF; step("R7 live bits drop with inputs");
    rts = 1; step("R8 rts quiet line grants");
    carrier = 1; step("R8 carrier blocks cts");
    full_duplex = 1; step("R9 full duplex ignores carrier");
    rts = 0; step("R9 full duplex follows rts low");
    carrier = 0; rts = 1; full_duplex = 0; step("R8 grant again");
    wr_en = 1; wr_data = 16'h0003; step("R7 write to cd cts ignored");
    rts = 0; step("R8 release");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule